// File: doc/BRIEF.md
# Sector Write-Protect Gate

This block decides whether a program or erase request may proceed on a memory split into sixteen sectors. Two active-low protect pins set the decision. One guards only the highest sector. The other guards every lower sector. The two pins act independently. When a modifying operation starts, the gate reads both pins at that clock edge. It then keeps those values as the effective lock status until the operation finishes. A pin change while the operation runs or is suspended therefore has no effect on the current operation.

A request that passes raises a one-cycle grant and enters an active state. Suspend and resume strobes move the operation between its running and suspended phases. A done or abort strobe returns it to idle. A request that fails raises a one-cycle reject and leaves the gate idle. While idle, the reported lock status follows the pins with one register delay. The lock status held during a suspend is therefore only replaced once the operation has ended. Reads never depend on the pins.

Top module: `sector_protect_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, grant, reject, busy and suspended are 0, and lock_top and lock_rest are 0.
- R2: The op_kind encodings are 2'b00 = read, 2'b01 = program, 2'b10 = erase and 2'b11 = reserved. The reserved code behaves as a read. A read or reserved start while idle gives grant = 1 in the following cycle, whatever the pins and sector are. It gives no reject, and busy stays 0.
- R3: A program or erase start while idle, aimed at sector 15 with top_lock_n low at that clock edge, gives reject = 1 for one cycle in the following cycle and no grant. Busy stays 0.
- R4: A program or erase start while idle, aimed at sectors 0 to 14 with wp_n low at that edge, is rejected the same way. wp_n has no effect on sector 15, and top_lock_n has no effect on sectors 0 to 14.
- R5: A program or erase start while idle that is not blocked gives grant = 1 for one cycle and busy = 1, both from the following cycle.
- R6: While idle, lock_top and lock_rest equal the inverted values of top_lock_n and wp_n at the previous clock edge.
- R7: From the start edge of a granted operation until one cycle after its done or abort edge, lock_top and lock_rest hold the inverted pin values taken at the start edge. Pin changes in that window, including during suspend, are applied only afterwards.
- R8: An op_start while busy is ignored: it gives no grant, no reject and no state change.
- R9: susp_req while busy and running sets suspended from the next cycle. resume_req while suspended clears it. Either strobe has no effect at any other time.
- R10: op_done or op_abort while busy clears busy and suspended from the next cycle. Either one overrides a suspend or resume strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Operation start strobe |
| op_kind | input | 2 | Operation type: 00 read, 01 program, 10 erase, 11 reserved |
| op_sector | input | 4 | Target sector index |
| op_done | input | 1 | Active operation has completed |
| op_abort | input | 1 | Active operation is abandoned |
| susp_req | input | 1 | Suspend the running operation |
| resume_req | input | 1 | Resume the suspended operation |
| top_lock_n | input | 1 | Active-low protect pin for the top sector |
| wp_n | input | 1 | Active-low protect pin for all other sectors |
| grant | output | 1 | One-cycle pulse: request allowed |
| reject | output | 1 | One-cycle pulse: request blocked |
| busy | output | 1 | A program or erase operation is active |
| suspended | output | 1 | The active operation is suspended |
| lock_top | output | 1 | Effective lock of the top sector |
| lock_rest | output | 1 | Effective lock of the lower sectors |

## Verification
Several events can land in the same clock edge. A pin edge can coincide with a start strobe. A done or abort strobe can coincide with a suspend or resume strobe. The bench drives both pairs on purpose. A pin falls in the same cycle as a top-sector program start, which must be rejected because the pins are read at that edge. A suspend arrives with done, and the operation must end with suspended still 0. A random phase also produces these overlaps freely. A behavioural model compares every output on every clock and judges each case.

// File: rtl/spg_pkg.sv
// Shared types for the sector write-protect gate.
// Assumes a two-bit operation code; reserved code is handled as a read.
package spg_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SUSP = 2'd2
    } op_state_e;

    // True for the operation types that alter array contents.
    function automatic logic op_modifies(input logic [1:0] code);
        return (op_kind_e'(code) == OP_PROG) || (op_kind_e'(code) == OP_ERASE);
    endfunction

endpackage

// File: rtl/spg_region_check.sv
// Region check: decides whether a request is blocked by the live pins.
// Assumes the highest sector index is guarded by the top pin and all
// others by the general pin. Purely combinational.
module spg_region_check #(
    parameter int SECTORS = 16,
    parameter int SECT_W  = $clog2(SECTORS)
) (
    input  logic [SECT_W-1:0] sector,
    input  logic              modifies,
    input  logic              top_pin_n,
    input  logic              rest_pin_n,
    output logic              blocked
);
    localparam logic [SECT_W-1:0] TOP_IDX = SECT_W'(SECTORS - 1);

    logic is_top;

    // Classify the target and choose the pin that guards it.
    always_comb begin
        is_top  = (sector == TOP_IDX);
        blocked = modifies && (is_top ? !top_pin_n : !rest_pin_n);
    end
endmodule

// File: rtl/spg_lock_latch.sv
// Effective lock registers: one per protect pin. Each follows its
// inverted pin while not held, and freezes while an operation is active.
// Assumes hold is a registered signal that rises the cycle after a start.
module spg_lock_latch #(
    parameter int NPINS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [NPINS-1:0] pin_n,
    output logic [NPINS-1:0] lock
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic lock_q;

        // Track the pin while free, freeze while held.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_q <= 1'b0;
            end else if (!hold) begin
                lock_q <= !pin_n[i];
            end
        end

        assign lock[i] = lock_q;
    end
endmodule

// File: rtl/spg_op_ctrl.sv
// Operation phase control: idle, running and suspended.
// Ending an operation takes priority over suspend or resume.
// Assumes launch is only raised while idle.
module spg_op_ctrl
    import spg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic finish,
    input  logic susp_req,
    input  logic resume_req,
    output logic busy,
    output logic suspended
);
    op_state_e state_q, state_d;

    // Next phase from strobes, with finish ranked first.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_RUN;
            ST_RUN: begin
                if (finish)        state_d = ST_IDLE;
                else if (susp_req) state_d = ST_SUSP;
            end
            ST_SUSP: begin
                if (finish)          state_d = ST_IDLE;
                else if (resume_req) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign busy      = (state_q != ST_IDLE);
    assign suspended = (state_q == ST_SUSP);
endmodule

// File: rtl/sector_protect_gate.sv
// Sector write-protect gate top. Qualifies each start request against the
// two protect pins sampled at the start edge. It raises one-cycle grant or
// reject pulses, tracks the active operation and reports the effective
// lock status, which stays frozen from start until the operation ends.
// Assumes the done and abort strobes come from the operation engine.
module sector_protect_gate
    import spg_pkg::*;
#(
    parameter int SECTORS = 16,
    localparam int SECT_W = $clog2(SECTORS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [SECT_W-1:0] op_sector,
    input  logic              op_done,
    input  logic              op_abort,
    input  logic              susp_req,
    input  logic              resume_req,
    input  logic              top_lock_n,
    input  logic              wp_n,
    output logic              grant,
    output logic              reject,
    output logic              busy,
    output logic              suspended,
    output logic              lock_top,
    output logic              lock_rest
);
    localparam int NPINS = 2;

    logic             start_idle;
    logic             modifies;
    logic             blocked;
    logic             launch;
    logic             grant_q, reject_q;
    logic [NPINS-1:0] locks;

    // Qualify the start request against the current phase and type.
    always_comb begin
        start_idle = op_start && !busy;
        modifies   = op_modifies(op_kind);
        launch     = start_idle && modifies && !blocked;
    end

    spg_region_check #(.SECTORS(SECTORS), .SECT_W(SECT_W)) u_region (
        .sector     (op_sector),
        .modifies   (modifies),
        .top_pin_n  (top_lock_n),
        .rest_pin_n (wp_n),
        .blocked    (blocked)
    );

    spg_op_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .finish     (op_done || op_abort),
        .susp_req   (susp_req),
        .resume_req (resume_req),
        .busy       (busy),
        .suspended  (suspended)
    );

    spg_lock_latch #(.NPINS(NPINS)) u_locks (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (busy),
        .pin_n ({wp_n, top_lock_n}),
        .lock  (locks)
    );

    // Register the one-cycle decision pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q  <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            grant_q  <= start_idle && !blocked;
            reject_q <= start_idle && blocked;
        end
    end

    assign grant     = grant_q;
    assign reject    = reject_q;
    assign lock_top  = locks[0];
    assign lock_rest = locks[1];
endmodule

// File: rtl/sector_protect_gate_chk.sv
// Property checker for the sector write-protect gate, bound to the top.
module sector_protect_gate_chk #(
    parameter int SECTORS = 16,
    parameter int SECT_W  = $clog2(SECTORS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_start,
    input logic [1:0]        op_kind,
    input logic [SECT_W-1:0] op_sector,
    input logic              op_done,
    input logic              op_abort,
    input logic              susp_req,
    input logic              resume_req,
    input logic              top_lock_n,
    input logic              wp_n,
    input logic              grant,
    input logic              reject,
    input logic              busy,
    input logic              suspended,
    input logic              lock_top,
    input logic              lock_rest
);
    localparam logic [SECT_W-1:0] TOP_IDX = SECT_W'(SECTORS - 1);

    logic wr_kind;
    assign wr_kind = (op_kind == 2'b01) || (op_kind == 2'b10);

    p_read_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !busy && !wr_kind) |=> (grant && !reject && !busy));

    p_top_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !busy && wr_kind && op_sector == TOP_IDX && !top_lock_n)
        |=> (reject && !grant && !busy));

    p_rest_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !busy && wr_kind && op_sector != TOP_IDX && !wp_n)
        |=> (reject && !grant && !busy));

    p_pulse_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && reject));

    p_idle_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (lock_top == !$past(top_lock_n) && lock_rest == !$past(wp_n)));

    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(lock_top) && $stable(lock_rest)));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && busy) |=> (!grant && !reject));

    p_susp_inside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> busy);

    p_end_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_done || op_abort)) |=> (!busy && !suspended));
endmodule

bind sector_protect_gate sector_protect_gate_chk #(.SECTORS(SECTORS), .SECT_W(SECT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_start   (op_start),
    .op_kind    (op_kind),
    .op_sector  (op_sector),
    .op_done    (op_done),
    .op_abort   (op_abort),
    .susp_req   (susp_req),
    .resume_req (resume_req),
    .top_lock_n (top_lock_n),
    .wp_n       (wp_n),
    .grant      (grant),
    .reject     (reject),
    .busy       (busy),
    .suspended  (suspended),
    .lock_top   (lock_top),
    .lock_rest  (lock_rest)
);

// File: tb/sim_sector_protect_gate.sv
// Bench: directed scenarios plus random traffic, with a behavioural
// reference model compared against every output on every clock.
module sim_sector_protect_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0;
    logic [1:0] op_kind = 2'b00;
    logic [3:0] op_sector = 4'd0;
    logic       op_done = 1'b0, op_abort = 1'b0;
    logic       susp_req = 1'b0, resume_req = 1'b0;
    logic       top_lock_n = 1'b1, wp_n = 1'b1;
    logic       grant, reject, busy, suspended, lock_top, lock_rest;

    int n_total = 0;
    int n_fail  = 0;
    bit run_over = 1'b0;

    always #5 clk = ~clk;

    sector_protect_gate u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_sector(op_sector), .op_done(op_done), .op_abort(op_abort),
        .susp_req(susp_req), .resume_req(resume_req), .top_lock_n(top_lock_n),
        .wp_n(wp_n), .grant(grant), .reject(reject), .busy(busy),
        .suspended(suspended), .lock_top(lock_top), .lock_rest(lock_rest)
    );

    // Behavioural reference model, advanced at each rising edge.
    bit m_grant, m_reject, m_busy, m_susp, m_ltop, m_lrest, armed;
    always @(posedge clk) begin
        bit g, r, b, s, lt, lr, wr, blk;
        armed = 1'b1;
        if (!rst_n) begin
            {m_grant, m_reject, m_busy, m_susp, m_ltop, m_lrest} = '0;
        end else begin
            g = 0; r = 0; b = m_busy; s = m_susp; lt = m_ltop; lr = m_lrest;
            wr  = (op_kind == 2'b01) || (op_kind == 2'b10);
            blk = wr && ((op_sector == 4'd15) ? !top_lock_n : !wp_n);
            if (!m_busy) begin
                lt = !top_lock_n;
                lr = !wp_n;
                if (op_start) begin
                    if (blk) r = 1;
                    else begin g = 1; if (wr) b = 1; end
                end
            end else begin
                if (op_done || op_abort) begin b = 0; s = 0; end
                else if (!m_susp && susp_req) s = 1;
                else if (m_susp && resume_req) s = 0;
            end
            m_grant = g; m_reject = r; m_busy = b; m_susp = s; m_ltop = lt; m_lrest = lr;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        bit bad;
        if (armed && !run_over) begin
            bad = 0;
            n_total++;
            if (grant !== m_grant) begin bad = 1; $display("FAIL R5 model grant actual=%b expected=%b", grant, m_grant); end
            if (reject !== m_reject) begin bad = 1; $display("FAIL R3 model reject actual=%b expected=%b", reject, m_reject); end
            if (busy !== m_busy) begin bad = 1; $display("FAIL R10 model busy actual=%b expected=%b", busy, m_busy); end
            if (suspended !== m_susp) begin bad = 1; $display("FAIL R9 model suspended actual=%b expected=%b", suspended, m_susp); end
            if (lock_top !== m_ltop) begin bad = 1; $display("FAIL R7 model lock_top actual=%b expected=%b", lock_top, m_ltop); end
            if (lock_rest !== m_lrest) begin bad = 1; $display("FAIL R6 model lock_rest actual=%b expected=%b", lock_rest, m_lrest); end
            if (bad) n_fail++;
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic start_op(input logic [1:0] k, input logic [3:0] sec);
        op_start = 1'b1; op_kind = k; op_sector = sec;
        cyc();
        op_start = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!run_over) begin
            run_over = 1'b1;
            n_total++; n_fail++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) cyc();
        // R1: state during reset
        chk("R1", "grant in reset", grant, 1'b0);
        chk("R1", "busy in reset", busy, 1'b0);
        chk("R1", "lock_top in reset", lock_top, 1'b0);
        rst_n = 1'b1;
        cyc();
        chk("R1", "reject after reset", reject, 1'b0);
        chk("R1", "suspended after reset", suspended, 1'b0);

        // R2: read passes with both pins low
        top_lock_n = 1'b0; wp_n = 1'b0;
        start_op(2'b00, 4'd15);
        chk("R2", "read grant", grant, 1'b1);
        chk("R2", "read no busy", busy, 1'b0);
        cyc();
        chk("R6", "idle lock_top", lock_top, 1'b1);
        chk("R6", "idle lock_rest", lock_rest, 1'b1);
        start_op(2'b11, 4'd15);
        chk("R2", "reserved code grant", grant, 1'b1);
        chk("R2", "reserved code no reject", reject, 1'b0);

        // R3: top pin blocks sector 15
        top_lock_n = 1'b0; wp_n = 1'b1;
        start_op(2'b01, 4'd15);
        chk("R3", "top reject", reject, 1'b1);
        chk("R3", "top no busy", busy, 1'b0);
        cyc();
        chk("R3", "reject one cycle", reject, 1'b0);

        // R4: top pin does not guard lower sectors
        start_op(2'b10, 4'd3);
        chk("R4", "lower grant with top low", grant, 1'b1);
        chk("R5", "busy after grant", busy, 1'b1);
        op_done = 1'b1; cyc(); op_done = 1'b0;
        chk("R10", "done ends op", busy, 1'b0);

        // R4: general pin blocks lower, not sector 15
        top_lock_n = 1'b1; wp_n = 1'b0;
        start_op(2'b01, 4'd7);
        chk("R4", "lower reject", reject, 1'b1);
        start_op(2'b10, 4'd15);
        chk("R4", "top grant with wp low", grant, 1'b1);
        chk("R7", "latched lock_top", lock_top, 1'b0);
        chk("R7", "latched lock_rest", lock_rest, 1'b1);

        // R7, R8, R9: changes mid-operation and during suspend
        top_lock_n = 1'b0; wp_n = 1'b1;
        cyc();
        chk("R7", "lock_top held mid-op", lock_top, 1'b0);
        start_op(2'b01, 4'd2);
        chk("R8", "start while busy no grant", grant, 1'b0);
        chk("R8", "start while busy no reject", reject, 1'b0);
        susp_req = 1'b1; cyc(); susp_req = 1'b0;
        chk("R9", "suspend", suspended, 1'b1);
        wp_n = 1'b0;
        cyc(); cyc();
        chk("R7", "lock_rest held in suspend", lock_rest, 1'b1);
        resume_req = 1'b1; cyc(); resume_req = 1'b0;
        chk("R9", "resume", suspended, 1'b0);
        op_abort = 1'b1; cyc(); op_abort = 1'b0;
        chk("R10", "abort ends op", busy, 1'b0);
        chk("R7", "lock_top on abort edge", lock_top, 1'b0);
        cyc();
        chk("R7", "deferred lock_top applied", lock_top, 1'b1);
        chk("R7", "deferred lock_rest applied", lock_rest, 1'b1);

        // R10: done together with suspend
        top_lock_n = 1'b1; wp_n = 1'b1;
        cyc();
        start_op(2'b01, 4'd0);
        susp_req = 1'b1; op_done = 1'b1; cyc();
        susp_req = 1'b0; op_done = 1'b0;
        chk("R10", "done beats suspend busy", busy, 1'b0);
        chk("R10", "done beats suspend susp", suspended, 1'b0);

        // R3: pin falls in the start cycle itself
        top_lock_n = 1'b0;
        start_op(2'b01, 4'd15);
        chk("R3", "pin sampled at start edge", reject, 1'b1);

        // R9: suspend while idle is ignored
        susp_req = 1'b1; cyc(); susp_req = 1'b0;
        chk("R9", "idle suspend ignored", suspended, 1'b0);

        // Random traffic checked against the model.
        for (int i = 0; i < 3000; i++) begin
            op_start   = ($urandom_range(0, 3) == 0);
            op_kind    = 2'($urandom_range(0, 3));
            op_sector  = ($urandom_range(0, 1) == 0) ? 4'd15 : 4'($urandom_range(0, 15));
            op_done    = ($urandom_range(0, 9) == 0);
            op_abort   = ($urandom_range(0, 19) == 0);
            susp_req   = ($urandom_range(0, 5) == 0);
            resume_req = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 4) == 0) top_lock_n = ~top_lock_n;
            if ($urandom_range(0, 4) == 0) wp_n = ~wp_n;
            cyc();
        end
        {op_start, op_done, op_abort, susp_req, resume_req} = '0;
        cyc();

        run_over = 1'b1;
        summary();
        $finish;
    end
endmodule